// File: doc/BRIEF.md
# Shared-Line Memory Target

This block is the memory end of a shared bus on which one set of 32 lines carries the address first and the data after it. The initiator opens a transaction by raising a valid strobe for one cycle with the address on the shared lines and a separate read/write control line. The target then spends a fixed number of cycles (five by default) reaching its internal storage of 64-bit words. After that, the word crosses the bus as two 32-bit beats, low half first.

On a read the target drives the shared lines in the two beat cycles and raises a ready strobe in each. On a write the initiator drives the two beats, each marked by the valid strobe, and the target stores them. With the default latency a whole transaction spans eight cycles, counted from the address cycle through the last beat. A new transaction can begin in the cycle after the last beat. A single initiator is assumed. The target ignores any request that arrives while a transaction is in flight.

Top module: `mux_bus_mem_target`

## Requirements
- R1: After reset the target is idle, does not drive the shared lines (output enable 0, ready 0, output lines 0), and every storage word reads as zero.
- R2: When the target is idle, a cycle with `bus_valid_i` high is an address cycle. The target takes the doubleword index from `bus_ad_i[6:3]` (16 words by default) and takes the direction from `bus_write_i`, where 1 means write.
- R3: For the five cycles after the address cycle (N+1 to N+5) the target neither drives the lines nor raises ready.
- R4: On a read, the target drives the stored word's bits [31:0] in cycle N+6 and its bits [63:32] in cycle N+7. Output enable and ready are high in exactly those two cycles.
- R5: On a write, the target stores `bus_ad_i` into bits [31:0] in cycle N+6 and into bits [63:32] in cycle N+7, each only when `bus_valid_i` is high in that cycle. The target never drives the lines or raises ready during a write.
- R6: A write beat cycle with `bus_valid_i` low leaves that half of the stored word unchanged.
- R7: Requests in cycles N+1 to N+7 are ignored. A new address cycle is accepted at N+8 at the earliest.
- R8: Whenever output enable is low, `bus_ad_o` is zero.
- R9: Address bits [2:0], and the bits above the index field, do not select storage. Addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid_i | input | 1 | Initiator strobe marking an address cycle or a write beat |
| bus_write_i | input | 1 | Direction control: 1 write, 0 read (sampled in the address cycle) |
| bus_ad_i | input | 32 | Shared lines as seen by the target: address, then write data |
| bus_ad_o | output | 32 | Read data the target places on the shared lines |
| bus_ad_oe_o | output | 1 | Target drives the shared lines this cycle |
| tgt_ready_o | output | 1 | Target marks a read data beat |

## Verification
Two things can coincide in one cycle. A fresh request can arrive while the target is still waiting on storage or sending beats. The bench raises the strobe during a wait cycle, using the opposite direction and a different index, and then confirms that the running transaction's timing and data are undisturbed and that the other word was not written. The end of one transaction can also meet the start of the next. The bench issues back-to-back transactions at cycle N+8, and a random mix of reads, full writes and half writes, each checked against a bench storage model.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACCESS  = 2'd1,
    PH_BEAT_LO = 2'd2,
    PH_BEAT_HI = 2'd3
  } mbt_phase_e;
endpackage

// File: rtl/mbt_sequencer.sv
module mbt_sequencer
  import mbt_pkg::*;
#(
  parameter int WAIT_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  output mbt_phase_e phase_o,
  output logic       accept_o,
  output logic       capture_o
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  mbt_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (req_i) begin
        phase_d = PH_ACCESS;
        cnt_d   = '0;
      end
      PH_ACCESS: begin
        if (cnt_q == LAST) phase_d = PH_BEAT_LO;
        else               cnt_d   = cnt_q + 1'b1;
      end
      PH_BEAT_LO: phase_d = PH_BEAT_HI;
      PH_BEAT_HI: phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o   = phase_q;
  assign accept_o  = (phase_q == PH_IDLE) && req_i;
  assign capture_o = (phase_q == PH_ACCESS) && (cnt_q == LAST);

  // Independent count of access cycles, used to check the wait length.
  logic [7:0] chk_acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     chk_acc_q <= '0;
    else if (phase_q == PH_ACCESS)  chk_acc_q <= chk_acc_q + 8'd1;
    else                            chk_acc_q <= '0;
  end

  // R3: exactly WAIT_CYC access cycles precede the first beat
  a_r3_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BEAT_LO) |-> (chk_acc_q == 8'(WAIT_CYC)));
  // R2: an idle request starts the access wait
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && req_i) |=> (phase_q == PH_ACCESS));
  // R7: the high beat is always the last busy cycle
  a_r7_free_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BEAT_HI) |=> (phase_q == PH_IDLE));
  // R7: busy phases never jump back to access
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BEAT_LO) |=> (phase_q == PH_BEAT_HI));
endmodule

// File: rtl/mbt_storage.sv
module mbt_storage #(
  parameter int DEPTH  = 16,
  parameter int HALF_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic                capture_i,
  output logic [2*HALF_W-1:0] rd_word_o
);
  logic [2*HALF_W-1:0] mem_q [DEPTH];
  logic [2*HALF_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (wr_lo_i) mem_q[idx_i][HALF_W-1:0]        <= wdata_i;
      if (wr_hi_i) mem_q[idx_i][2*HALF_W-1:HALF_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (capture_i) rd_q <= mem_q[idx_i];
  end

  assign rd_word_o = rd_q;

  // R5: the two halves of a word are never written in the same cycle
  a_r5_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo_i && wr_hi_i));
endmodule

// File: rtl/mbt_beat_drive.sv
module mbt_beat_drive
  import mbt_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  mbt_phase_e          phase_i,
  input  logic                is_write_i,
  input  logic [2*HALF_W-1:0] rd_word_i,
  output logic [HALF_W-1:0]   bus_ad_o,
  output logic                oe_o,
  output logic                ready_o
);
  logic in_beat;

  always_comb begin
    in_beat  = (phase_i == PH_BEAT_LO) || (phase_i == PH_BEAT_HI);
    oe_o     = in_beat && !is_write_i;
    ready_o  = oe_o;
    bus_ad_o = '0;
    if (oe_o) begin
      bus_ad_o = (phase_i == PH_BEAT_HI) ? rd_word_i[2*HALF_W-1:HALF_W]
                                         : rd_word_i[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/mux_bus_mem_target.sv
module mux_bus_mem_target
  import mbt_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int DEPTH    = 16,
  parameter int WAIT_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic [BUS_W-1:0] bus_ad_i,
  output logic [BUS_W-1:0] bus_ad_o,
  output logic             bus_ad_oe_o,
  output logic             tgt_ready_o
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_LO = 3;

  // Reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mbt_phase_e          phase;
  logic                accept, capture;
  logic [IDX_W-1:0]    idx_q;
  logic                wr_q;
  logic [2*BUS_W-1:0]  rd_word;
  logic                wr_lo, wr_hi;

  mbt_sequencer #(.WAIT_CYC(WAIT_CYC)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_i     (bus_valid_i),
    .phase_o   (phase),
    .accept_o  (accept),
    .capture_o (capture)
  );

  // Request register, loaded only in the address cycle
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q <= '0;
      wr_q  <= 1'b0;
    end else if (accept) begin
      idx_q <= bus_ad_i[IDX_LO +: IDX_W];
      wr_q  <= bus_write_i;
    end
  end

  assign wr_lo = wr_q && bus_valid_i && (phase == PH_BEAT_LO);
  assign wr_hi = wr_q && bus_valid_i && (phase == PH_BEAT_HI);

  mbt_storage #(.DEPTH(DEPTH), .HALF_W(BUS_W)) mem_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .idx_i     (idx_q),
    .wdata_i   (bus_ad_i),
    .capture_i (capture),
    .rd_word_o (rd_word)
  );

  mbt_beat_drive #(.HALF_W(BUS_W)) drv_i (
    .phase_i    (phase),
    .is_write_i (wr_q),
    .rd_word_i  (rd_word),
    .bus_ad_o   (bus_ad_o),
    .oe_o       (bus_ad_oe_o),
    .ready_o    (tgt_ready_o)
  );

  // R4: read beats come as an adjacent pair
  a_r4_beat_pair: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tgt_ready_o) |=> tgt_ready_o);
  // R4: ready never lasts three cycles
  a_r4_two_only: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tgt_ready_o && $past(tgt_ready_o)) |=> !tgt_ready_o);
  // R5: the target stays off the lines during a write transaction
  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_q && phase != PH_IDLE) |-> !bus_ad_oe_o);
  // R8: undriven output is zero
  a_r8_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_ad_oe_o |-> (bus_ad_o == '0));
  // R7: request register holds through a transaction
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(idx_q));
endmodule

// File: tb/mux_bus_mem_target_tb.sv
`timescale 1ns/1ps
module mux_bus_mem_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [31:0] bus_ad_i = '0;
  logic [31:0] bus_ad_o;
  logic        bus_ad_oe_o;
  logic        tgt_ready_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] model [16];

  always #2 clk = ~clk;

  mux_bus_mem_target dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid_i),
    .bus_write_i(bus_write_i), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
    .bus_ad_oe_o(bus_ad_oe_o), .tgt_ready_o(tgt_ready_o)
  );

  function automatic int idx_of(input logic [31:0] a);
    return int'(a[6:3]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_ad_i = '0;
  endtask

  // Starts at a falling edge that opens the address cycle; ends at the
  // falling edge opening cycle N+8.
  task automatic txn(input bit wr, input logic [31:0] addr, input logic [63:0] wd,
                     input bit vlo, input bit vhi, input bit poke);
    logic [63:0] exp = model[idx_of(addr)];
    bus_valid_i = 1'b1; bus_write_i = wr; bus_ad_i = addr;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      idle_inputs();
      if (k <= 5) begin
        chk(!bus_ad_oe_o && !tgt_ready_o && bus_ad_o == 0, "R3 wait quiet",
            {bus_ad_oe_o, tgt_ready_o, bus_ad_o}, 64'h0);
        if (k == 3 && poke) begin
          bus_valid_i = 1'b1; bus_write_i = !wr; bus_ad_i = addr ^ 32'h8;
        end
      end else if (!wr) begin
        chk(bus_ad_oe_o && tgt_ready_o, "R4 read beat strobes",
            {bus_ad_oe_o, tgt_ready_o}, 64'h3);
        chk(bus_ad_o == (k == 6 ? exp[31:0] : exp[63:32]), "R4 read beat data",
            bus_ad_o, (k == 6 ? exp[31:0] : exp[63:32]));
      end else begin
        chk(!bus_ad_oe_o && !tgt_ready_o && bus_ad_o == 0, "R5 R8 write no drive",
            {bus_ad_oe_o, tgt_ready_o, bus_ad_o}, 64'h0);
        bus_valid_i = (k == 6) ? vlo : vhi;
        bus_ad_i    = (k == 6) ? wd[31:0] : wd[63:32];
      end
    end
    @(negedge clk);
    idle_inputs();
    chk(!bus_ad_oe_o && !tgt_ready_o && bus_ad_o == 0, "R7 R8 free at N+8",
        {bus_ad_oe_o, tgt_ready_o, bus_ad_o}, 64'h0);
    if (wr) begin
      if (vlo) model[idx_of(addr)][31:0]  = wd[31:0];
      if (vhi) model[idx_of(addr)][63:32] = wd[63:32];
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state at the ports
    chk(!bus_ad_oe_o && !tgt_ready_o && bus_ad_o == 0, "R1 reset quiet",
        {bus_ad_oe_o, tgt_ready_o, bus_ad_o}, 64'h0);
    // R1 storage zero after reset, R2 index decode
    txn(1'b0, 32'h0000_0028, '0, 1'b0, 1'b0, 1'b0);
    // R5 full write then R9 aliased read back (low bits and high bits differ)
    txn(1'b1, 32'h0000_0018, 64'h1111_2222_3333_4444, 1'b1, 1'b1, 1'b0);
    txn(1'b0, 32'hF000_009D, '0, 1'b0, 1'b0, 1'b0);
    // R6 half writes keep the other half
    txn(1'b1, 32'h0000_0018, 64'hAAAA_0000_0000_5555, 1'b1, 1'b0, 1'b0);
    txn(1'b0, 32'h0000_0018, '0, 1'b0, 1'b0, 1'b0);
    txn(1'b1, 32'h0000_0018, 64'hBEEF_0000_0000_7777, 1'b0, 1'b1, 1'b0);
    txn(1'b0, 32'h0000_0018, '0, 1'b0, 1'b0, 1'b0);
    // R7 intruding write during a read's wait: neighbour word untouched
    txn(1'b0, 32'h0000_0018, '0, 1'b0, 1'b0, 1'b1);
    txn(1'b0, 32'h0000_0010, '0, 1'b0, 1'b0, 1'b0);
    // R7 intruding read during a write, then R2 back-to-back readback
    txn(1'b1, 32'h0000_0040, 64'hCAFE_F00D_0123_4567, 1'b1, 1'b1, 1'b1);
    txn(1'b0, 32'h0000_0040, '0, 1'b0, 1'b0, 1'b0);
    txn(1'b0, 32'h0000_0048, '0, 1'b0, 1'b0, 1'b0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = $urandom;
      logic [63:0] d = {$urandom, $urandom};
      bit w  = ($urandom % 2) == 1;
      bit vl = ($urandom % 4) != 0;
      bit vh = ($urandom % 4) != 0;
      bit pk = ($urandom % 5) == 0;
      txn(w, a, d, vl, vh, pk);
    end
    for (int i = 0; i < 16; i++) txn(1'b0, 32'(i * 8), '0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule